// File: doc/BRIEF.md
# Vector Zero-Test Condition Flag Unit

This unit runs the small group of vector test instructions that reduce one 128-bit vector register to a single true/false result and store it in one of eight 1-bit condition flags. The unit decodes a 32-bit instruction word and presents the source register index to the register file. It then takes the register contents back on a combinational read port and checks them in one of ten ways. Two tests look at the register as a whole: is it zero, or is it nonzero. The other eight look at lanes of 8, 16, 32 or 64 bits: is any lane zero, or are all lanes nonzero.

The flag bank sits inside the unit, and all eight flags are visible at once on a parallel output. A word that carries the test opcode but is malformed raises a one-cycle illegal-instruction pulse. A well-formed word issued while the SIMD extension is off raises a one-cycle disabled-extension pulse. In both cases no flag is written. Words with any other opcode are left for other units and cause no action here.

Top module: `vzt_unit`

## Requirements
- R1: A word is claimed only when bits [31:15] equal 0111_0010_1001_1100_1. Any other word presented with `valid_i` changes no flag and raises no pulse. Bits [9:5] of a claimed word drive `src_idx_o`.
- R2: Sub-opcode bits [14:10] = 00110 writes 1 to the flag when all 128 source bits are zero, and 0 otherwise.
- R3: Sub-opcode 00111 writes 1 when the source register has at least one set bit, and 0 otherwise.
- R4: Sub-opcodes 01000, 01001, 01010 and 01011 write 1 when at least one lane is zero. The lanes are 8, 16, 32 and 64 bits wide respectively, giving 16, 8, 4 and 2 lanes.
- R5: Sub-opcodes 01100, 01101, 01110 and 01111 write 1 only when no lane is zero, with the same lane widths as R4.
- R6: Only the flag selected by bits [2:0] is written; the other seven keep their values. `flags_o[i]` is flag i.
- R7: The new flag value appears on `flags_o` right after the clock edge that samples `valid_i`.
- R8: A claimed word with bits [4:3] not 00, or with a sub-opcode outside 00110..01111, makes `illegal_o` high for exactly the cycle after that edge and writes no flag. This holds whatever `simd_en_i` is.
- R9: A well-formed claimed word with `simd_en_i` low makes `simd_off_o` high for exactly the cycle after that edge and writes no flag. `illegal_o` and `simd_off_o` are never high together.
- R10: While reset is asserted, all eight flags are 0 and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word present this cycle |
| insn_i | input | 32 | Instruction word |
| simd_en_i | input | 1 | SIMD extension enabled |
| src_idx_o | output | 5 | Source vector register index (bits [9:5]) |
| src_data_i | input | 128 | Source register contents, returned combinationally |
| flags_o | output | 8 | All condition flags in parallel |
| illegal_o | output | 1 | Illegal-instruction pulse |
| simd_off_o | output | 1 | Disabled-extension pulse |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector and eight flags. With these values every lane width from byte to doubleword is exercised, at 16, 8, 4 and 2 lanes, and every flag index can be addressed. The source vectors are shaped so that they are all zero, have exactly one zeroed lane of a chosen width, or are dense. Both outcomes of every any-zero and all-nonzero test therefore occur at every lane width, together with malformed, foreign-opcode and extension-off words.

// File: rtl/vzt_pkg.sv
package vzt_pkg;
  localparam logic [16:0] VZT_OPCODE = 17'b01110010100111001;
  localparam logic [4:0]  SUB_MIN    = 5'b00110;
  localparam logic [4:0]  SUB_MAX    = 5'b01111;
  localparam int          NUM_SIZES  = 4;

  typedef enum logic [1:0] {
    K_WHOLE_Z  = 2'd0,
    K_WHOLE_NZ = 2'd1,
    K_ANY_Z    = 2'd2,
    K_ALL_NZ   = 2'd3
  } test_kind_e;
endpackage

// File: rtl/vzt_decode.sv
module vzt_decode
  import vzt_pkg::*;
#(
  parameter int FLAG_W = 3
) (
  input  logic [31:0]       insn_i,
  output logic              match_o,
  output logic              legal_o,
  output test_kind_e        kind_o,
  output logic [1:0]        size_o,
  output logic [4:0]        src_o,
  output logic [FLAG_W-1:0] idx_o
);
  logic [4:0] sub;
  assign sub     = insn_i[14:10];
  assign match_o = (insn_i[31:15] == VZT_OPCODE);
  assign legal_o = (insn_i[4:3] == 2'b00) && (sub >= SUB_MIN) && (sub <= SUB_MAX);
  assign src_o   = insn_i[9:5];
  assign idx_o   = insn_i[FLAG_W-1:0];
  assign size_o  = sub[1:0];

  always_comb begin
    unique case (sub[3:2])
      2'b10:   kind_o = K_ANY_Z;
      2'b11:   kind_o = K_ALL_NZ;
      default: kind_o = sub[0] ? K_WHOLE_NZ : K_WHOLE_Z;
    endcase
  end
endmodule

// File: rtl/vzt_lane_zero.sv
module vzt_lane_zero
  import vzt_pkg::*;
#(
  parameter int VLEN = 128
) (
  input  logic [VLEN-1:0]      data_i,
  output logic [NUM_SIZES-1:0] any_zero_o,
  output logic                 all_zero_o
);
  assign all_zero_o = ~|data_i;

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int LW = 8 << s;
    localparam int NL = VLEN / LW;
    logic [NL-1:0] lane_z;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      assign lane_z[l] = ~|data_i[l*LW +: LW];
    end
    assign any_zero_o[s] = |lane_z;
  end
endmodule

// File: rtl/vzt_flag_bank.sv
module vzt_flag_bank #(
  parameter int NFLAG  = 8,
  parameter int FLAG_W = $clog2(NFLAG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [FLAG_W-1:0] idx_i,
  input  logic              bit_i,
  output logic [NFLAG-1:0]  flags_o
);
  logic [NFLAG-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   flags_q <= '0;
    else if (we_i) flags_q[idx_i] <= bit_i;
  end

  assign flags_o = flags_q;

  assert_single_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(flags_q ^ $past(flags_q)) <= 1);

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flags_q));
endmodule

// File: rtl/vzt_unit.sv
module vzt_unit
  import vzt_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int NFLAG = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [31:0]      insn_i,
  input  logic             simd_en_i,
  output logic [4:0]       src_idx_o,
  input  logic [VLEN-1:0]  src_data_i,
  output logic [NFLAG-1:0] flags_o,
  output logic             illegal_o,
  output logic             simd_off_o
);
  localparam int FLAG_W = $clog2(NFLAG);

  logic              match, legal;
  test_kind_e        kind;
  logic [1:0]        size;
  logic [FLAG_W-1:0] idx;
  logic [NUM_SIZES-1:0] any_zero;
  logic              all_zero, result, we;
  logic              illegal_q, off_q;

  vzt_decode #(.FLAG_W(FLAG_W)) u_dec (
    .insn_i (insn_i),
    .match_o(match),
    .legal_o(legal),
    .kind_o (kind),
    .size_o (size),
    .src_o  (src_idx_o),
    .idx_o  (idx)
  );

  vzt_lane_zero #(.VLEN(VLEN)) u_lz (
    .data_i    (src_data_i),
    .any_zero_o(any_zero),
    .all_zero_o(all_zero)
  );

  always_comb begin
    unique case (kind)
      K_WHOLE_Z:  result = all_zero;
      K_WHOLE_NZ: result = ~all_zero;
      K_ANY_Z:    result = any_zero[size];
      default:    result = ~any_zero[size];
    endcase
  end

  assign we = valid_i && match && legal && simd_en_i;

  vzt_flag_bank #(.NFLAG(NFLAG), .FLAG_W(FLAG_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .idx_i  (idx),
    .bit_i  (result),
    .flags_o(flags_o)
  );

  // illegal wins over extension-off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      illegal_q <= 1'b0;
      off_q     <= 1'b0;
    end else begin
      illegal_q <= valid_i && match && !legal;
      off_q     <= valid_i && match && legal && !simd_en_i;
    end
  end

  assign illegal_o  = illegal_q;
  assign simd_off_o = off_q;

  assert_excl_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({illegal_o, simd_off_o}));

  assert_illegal_nowrite_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> flags_o == $past(flags_o));

  assert_off_nowrite_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    simd_off_o |-> flags_o == $past(flags_o));

  assert_foreign_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && insn_i[31:15] != VZT_OPCODE) |=> (!illegal_o && !simd_off_o && $stable(flags_o)));

  assert_whole_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && simd_en_i && insn_i[31:15] == VZT_OPCODE && insn_i[14:10] == 5'b00110 &&
     insn_i[4:3] == 2'b00 && src_data_i == '0) |=> flags_o[$past(insn_i[FLAG_W-1:0])]);
endmodule

// File: tb/sim_vzt_unit.sv
module sim_vzt_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [16:0] OPC = 17'b01110010100111001;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [31:0]  insn = '0;
  logic         simd_en = 1'b1;
  logic [4:0]   src_idx;
  logic [127:0] src_data;
  logic [7:0]   flags;
  logic         illegal, simd_off;

  logic [127:0] rf [32];
  logic [7:0]   mflags;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign src_data = rf[src_idx];

  vzt_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .insn_i(insn), .simd_en_i(simd_en),
    .src_idx_o(src_idx), .src_data_i(src_data), .flags_o(flags),
    .illegal_o(illegal), .simd_off_o(simd_off)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [4:0] sub, input logic [4:0] vj,
                                     input logic [2:0] cd, input logic [1:0] mid);
    return {OPC, sub, vj, mid, cd};
  endfunction

  function automatic logic exp_res(input logic [4:0] sub, input logic [127:0] v);
    int lw;
    logic anyz;
    logic [127:0] mask;
    if (sub == 5'd6) return v == '0;
    if (sub == 5'd7) return v != '0;
    lw = 8 << sub[1:0];
    mask = (128'd1 << lw) - 128'd1;
    anyz = 1'b0;
    for (int l = 0; l < 128 / lw; l++)
      if (((v >> (l * lw)) & mask) == '0) anyz = 1'b1;
    return sub[2] ? !anyz : anyz;
  endfunction

  function automatic string tag_of(input logic [4:0] sub);
    if (sub == 5'd6) return "R2";
    if (sub == 5'd7) return "R3";
    if (sub[2]) return "R5";
    return "R4";
  endfunction

  task automatic issue(input logic [31:0] w, input logic en);
    @(negedge clk);
    valid = 1'b1; insn = w; simd_en = en;
    @(negedge clk);
    valid = 1'b0; simd_en = 1'b1;
  endtask

  // vector with one zeroed lane of width 8<<s, otherwise all bytes nonzero
  function automatic logic [127:0] one_zero_lane(input int s, input int lane);
    logic [127:0] v;
    int lw;
    v = {16{8'h5a}};
    lw = 8 << s;
    for (int b = 0; b < lw; b++) v[lane * lw + b] = 1'b0;
    return v;
  endfunction

  task automatic run_legal(input logic [4:0] sub, input logic [4:0] vj, input logic [2:0] cd);
    logic e;
    e = exp_res(sub, rf[vj]);
    issue(mk(sub, vj, cd, 2'b00), 1'b1);
    mflags[cd] = e;
    check(tag_of(sub), {24'd0, flags}, {24'd0, mflags});
    check("R7", {30'd0, illegal, simd_off}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < 32; r++) rf[r] = {16{8'h11}} + 128'(r);
    rf[0] = '0;
    mflags = '0;
    #(CLK_PERIOD * 2 + 1);
    check("R10", {22'd0, flags, illegal, simd_off}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    check("R10", {24'd0, flags}, 32'd0);

    // whole-register tests
    run_legal(5'd6, 5'd0, 3'd0);
    check("R2", {31'd0, flags[0]}, 32'd1);
    run_legal(5'd7, 5'd0, 3'd1);
    check("R3", {31'd0, flags[1]}, 32'd0);
    run_legal(5'd7, 5'd5, 3'd1);
    check("R3", {31'd0, flags[1]}, 32'd1);
    run_legal(5'd6, 5'd5, 3'd0);

    // one zero lane at each width: any-zero true only at widths <= that lane
    for (int s = 0; s < 4; s++) begin
      rf[20] = one_zero_lane(s, (s == 3) ? 1 : 2);
      for (int t = 0; t < 4; t++) begin
        run_legal(5'b01000 | 5'(t), 5'd20, 3'(t));
        run_legal(5'b01100 | 5'(t), 5'd20, 3'(t + 4));
      end
    end

    // only addressed flag changes
    run_legal(5'd6, 5'd0, 3'd7);
    run_legal(5'd7, 5'd0, 3'd7);
    check("R6", {24'd0, flags}, {24'd0, mflags});

    // malformed: bits [4:3], and subop out of range, also with simd off
    issue(mk(5'd6, 5'd0, 3'd2, 2'b01), 1'b1);
    check("R8", {30'd0, illegal, simd_off}, 32'd2);
    check("R8", {24'd0, flags}, {24'd0, mflags});
    @(negedge clk);
    check("R8", {31'd0, illegal}, 32'd0);
    issue(mk(5'd5, 5'd0, 3'd2, 2'b00), 1'b0);
    check("R8", {30'd0, illegal, simd_off}, 32'd2);
    issue(mk(5'd16, 5'd0, 3'd2, 2'b00), 1'b1);
    check("R8", {30'd0, illegal, simd_off}, 32'd2);

    // extension off
    issue(mk(5'd6, 5'd0, 3'd3, 2'b00), 1'b0);
    check("R9", {30'd0, illegal, simd_off}, 32'd1);
    check("R9", {24'd0, flags}, {24'd0, mflags});
    @(negedge clk);
    check("R9", {31'd0, simd_off}, 32'd0);

    // foreign opcode
    issue({OPC ^ 17'h1, 5'd6, 5'd0, 2'b00, 3'd4}, 1'b1);
    check("R1", {22'd0, flags, illegal, simd_off}, {22'd0, mflags, 2'b00});

    // source index routing
    @(negedge clk); insn = mk(5'd6, 5'd19, 3'd0, 2'b00);
    #1 check("R1", {27'd0, src_idx}, 32'd19);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int kind;
      logic [4:0] vj, sub;
      logic [2:0] cd;
      vj = 5'($urandom_range(1, 31));
      kind = $urandom_range(0, 7);
      if (kind == 0) rf[vj] = '0;
      else if (kind <= 4) rf[vj] = one_zero_lane(kind - 1, $urandom_range(0, 1));
      else rf[vj] = {$urandom, $urandom, $urandom, $urandom} | 128'h0101_0101_0101_0101_0101_0101_0101_0101;
      cd = 3'($urandom);
      case ($urandom_range(0, 9))
        0: begin
          issue(mk(5'($urandom_range(6, 15)), vj, cd, 2'($urandom_range(1, 3))), 1'($urandom));
          check("R8", {22'd0, flags, illegal, simd_off}, {22'd0, mflags, 2'b10});
        end
        1: begin
          issue(mk(5'($urandom_range(6, 15)), vj, cd, 2'b00), 1'b0);
          check("R9", {22'd0, flags, illegal, simd_off}, {22'd0, mflags, 2'b01});
        end
        2: begin
          issue({17'($urandom), 15'($urandom)} & 32'hFFFF7FFF, 1'b1);
          check("R1", {22'd0, flags, illegal, simd_off}, {22'd0, mflags, 2'b00});
        end
        default: begin
          sub = 5'($urandom_range(6, 15));
          run_legal(sub, vj, cd);
        end
      endcase
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule